// File: doc/BRIEF.md
# Circulant-Structured Systematic LDPC Encoder (32,16)

This block encodes a 16-bit information word into a 32-bit codeword of a binary (32,16) low-density parity-check code. The parity-check matrix is systematic, H = [I | P]. The 16x16 identity part covers the parity positions. The 16x16 part P is a 2x2 arrangement of 8x8 circulants, and each circulant is an identity matrix whose rows are cyclically rotated right by a fixed amount. Because of this structure, each parity bit is the XOR of a handful of information bits picked out by the circulant shifts. No generator matrix is stored.

A word presented with `in_valid` is encoded by a purely combinational XOR network. The result is captured into an output register, so the codeword and `out_valid` appear one clock later. The circulant size and the four shifts are parameters, with defaults 2, 3 (top row of blocks) and 5, 7 (bottom row). A further parameter can replace any one block with the all-zero matrix, which makes the code irregular.

Top module: `ldpc_circ_enc`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `out_valid` is 0 and `out_code` is all zeros.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: When `out_valid` is 1, `out_code[15:0]` equals the `in_info` word that was accepted one cycle earlier.
- R4: Parity bit r (0..15) sits at `out_code[16+r]`. It is the XOR of `in_info[b*8 + ((r mod 8) + s) mod 8]` over block columns b = 0 and 1, where s is the shift of block (r div 8, b). The default shifts are 2, 3 for block row 0 and 5, 7 for block row 1.
- R5: Every codeword produced satisfies H·cᵀ = 0 over GF(2), with H = [I | P]. Row r of H has a 1 in the parity column of bit r and in each information column named in R4.
- R6: `ZERO_POS` set to 0..3 replaces the block at row-major position ZERO_POS with the zero matrix (0 = top-left, 1 = top-right, 2 = bottom-left, 3 = bottom-right), so that block adds nothing to the parity. The value 4 keeps all four circulants.
- R7: When `in_valid` is 0, `out_code` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Information word is present |
| in_info | input | 16 | Information word |
| out_valid | output | 1 | Codeword register holds a new result |
| out_code | output | 32 | Codeword {parity[15:0], info[15:0]} |

## Verification
The bench builds two copies of the encoder side by side: one with the default shifts and no zero block, and one with `ZERO_POS = 1`, which empties the top-right block. Both copies receive all 65536 information words back to back. This confirms the per-bit parity equations and the zero syndrome for every possible word, in both the regular and the irregular form of the code. Valid gaps and a reset in mid-stream show the strobe timing and that the codeword holds while the input is idle.

// File: rtl/ldpc_circ_enc.sv
module ldpc_circ_enc #(
  parameter int SUB      = 8,
  parameter int SH_00    = 2,
  parameter int SH_01    = 3,
  parameter int SH_10    = 5,
  parameter int SH_11    = 7,
  parameter int ZERO_POS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2*SUB-1:0]   in_info,
  output logic               out_valid,
  output logic [4*SUB-1:0]   out_code
);
  localparam int K = 2 * SUB;
  localparam int N = 2 * K;

  function automatic int blk_shift(input int br, input int bc);
    case (br * 2 + bc)
      0:       return SH_00;
      1:       return SH_01;
      2:       return SH_10;
      default: return SH_11;
    endcase
  endfunction

  function automatic logic [K-1:0] row_mask(input int r);
    logic [K-1:0] m;
    m = '0;
    for (int bc = 0; bc < 2; bc++)
      if ((r / SUB) * 2 + bc != ZERO_POS)
        m[bc * SUB + ((r % SUB) + blk_shift(r / SUB, bc)) % SUB] = 1'b1;
    return m;
  endfunction

  logic [K-1:0] parity;

  for (genvar r = 0; r < K; r++) begin : g_par
    assign parity[r] = ^(in_info & row_mask(r));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= {parity, in_info};
    end
  end

  logic [K-1:0] syndrome;
  for (genvar r = 0; r < K; r++) begin : g_syn
    assign syndrome[r] = out_code[K + r] ^ (^(out_code[K-1:0] & row_mask(r)));
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_code == '0));

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_info_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_code[K-1:0] == $past(in_info));

  assert_zero_syndrome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> syndrome == '0);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> $stable(out_code));

  initial begin
    assert_param_range_R6: assert (ZERO_POS >= 0 && ZERO_POS <= 4 && N == 4 * SUB)
      else $error("ZERO_POS out of range");
  end
endmodule

// File: tb/tb_ldpc_circ_enc.sv
module tb_ldpc_circ_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_info = '0;
  logic        out_valid, zv;
  logic [31:0] out_code, zc;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ldpc_circ_enc dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_info(in_info),
                     .out_valid(out_valid), .out_code(out_code));
  ldpc_circ_enc #(.ZERO_POS(1)) dut_z (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                     .in_info(in_info), .out_valid(zv), .out_code(zc));

  function automatic logic [31:0] ref_code(input logic [15:0] u, input int zp);
    int sh [4] = '{2, 3, 5, 7};
    logic [15:0] p = '0;
    for (int r = 0; r < 16; r++)
      for (int b = 0; b < 2; b++)
        if ((r / 8) * 2 + b != zp) p[r] ^= u[b * 8 + ((r % 8) + sh[(r / 8) * 2 + b]) % 8];
    return {p, u};
  endfunction

  function automatic logic [15:0] syn(input logic [31:0] c, input int zp);
    int sh [4] = '{2, 3, 5, 7};
    logic [15:0] s;
    for (int r = 0; r < 16; r++) begin
      s[r] = c[16 + r];
      for (int col = 0; col < 16; col++)
        if ((r / 8) * 2 + col / 8 != zp && ((r % 8) + sh[(r / 8) * 2 + col / 8]) % 8 == col % 8)
          s[r] ^= c[col];
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b1; in_info = 16'hBEEF;
    repeat (3) @(negedge clk);
    check("R1 valid", {63'd0, out_valid}, 64'd0);
    check("R1 code", {32'd0, out_code}, 64'd0);
    check("R1 zvalid", {63'd0, zv}, 64'd0);
    in_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_single;
    in_valid = 1'b1; in_info = 16'h0001;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid one cycle later", {63'd0, out_valid}, 64'd1);
    check("R3 info", {48'd0, out_code[15:0]}, 64'h0001);
    check("R4 parity of unit word", {32'd0, out_code}, {32'd0, ref_code(16'h0001, 4)});
    @(negedge clk);
    check("R2 valid drops", {63'd0, out_valid}, 64'd0);
    check("R7 hold", {32'd0, out_code}, {32'd0, ref_code(16'h0001, 4)});
    in_info = 16'h1234;
    @(negedge clk);
    check("R7 hold under changing info", {32'd0, out_code}, {32'd0, ref_code(16'h0001, 4)});
  endtask

  task automatic t_unit_words;
    for (int i = 0; i < 16; i++) begin
      in_valid = 1'b1; in_info = 16'(1 << i);
      @(negedge clk);
      check("R4 unit column", {32'd0, out_code}, {32'd0, ref_code(16'(1 << i), 4)});
      check("R6 unit column zeroed block", {32'd0, zc}, {32'd0, ref_code(16'(1 << i), 1)});
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_exhaustive;
    in_valid = 1'b1; in_info = 16'd0;
    @(negedge clk);
    for (int w = 1; w <= 65536; w++) begin
      check("R5 syndrome", {48'd0, syn(out_code, 4)}, 64'd0);
      check("R6 syndrome zeroed block", {48'd0, syn(zc, 1)}, 64'd0);
      check("R4 codeword", {32'd0, out_code}, {32'd0, ref_code(16'(w - 1), 4)});
      check("R6 codeword", {32'd0, zc}, {32'd0, ref_code(16'(w - 1), 1)});
      if (w < 65536) in_info = 16'(w); else in_valid = 1'b0;
      @(negedge clk);
    end
    check("R2 stream end", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_gap_and_reset;
    in_valid = 1'b1; in_info = 16'hA5C3;
    @(negedge clk);
    in_valid = 1'b0; in_info = 16'hFFFF;
    check("R3 gap first", {48'd0, out_code[15:0]}, 64'hA5C3);
    @(negedge clk);
    check("R2 gap", {63'd0, out_valid}, 64'd0);
    check("R7 gap hold", {32'd0, out_code}, {32'd0, ref_code(16'hA5C3, 4)});
    in_valid = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 mid reset code", {32'd0, out_code}, 64'd0);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_unit_words();
        t_exhaustive();
        t_gap_and_reset();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule